// File: doc/BRIEF.md
# Raw-Sample Range Trip Guard

This block watches each incoming frame of raw signed ADC samples, one sample per channel, and compares every channel against an upper and a lower trip limit expressed in raw counts. No scaling happens first, so the check sits only a few clocks behind the converter. A channel must break a limit on a programmable number of back-to-back frames before its range flag rises. Any raised flag latches a fault, and the fault drives every PWM gate command to zero.

The limits for each channel are stored as one packed word that holds both bounds. All channel words are read together in a single clock. The comparison result is registered on the clock after that read. Software loads a channel's limits through a small write port. The fault is cleared by a clear input, but only once every flag has dropped.

Top module: `trip_guard`

## Requirements
- R1: After reset, every range flag, the fault and all gate outputs are 0. Every channel's limits are fully open (upper = +32767, lower = -32768), so no sample can violate them.
- R2: A cycle with `lim_we` high stores `lim_upper` and `lim_lower` for channel `lim_ch`. Frames accepted on later edges are checked against the new values.
- R3: A sample strictly greater than its channel's upper limit is a violation. A sample equal to the limit is not. Samples and limits are 16-bit two's complement, and channel i occupies `frame_data[16*i+15:16*i]`.
- R4: A sample strictly less than its channel's lower limit is a violation. A sample equal to the limit is not.
- R5: With `debounce_len` = D, a channel's flag rises on the (D+1)-th consecutive violating valid frame. With D = 0 it rises on the first violating frame.
- R6: A valid in-range frame clears that channel's run count and its flag. Cycles without `frame_valid` leave the counts and flags unchanged.
- R7: A flag update appears on the third rising edge, counting the edge that samples `frame_valid` high as the first.
- R8: `fault` rises on the clock after any flag is high, and it stays high after the flags drop.
- R9: `fault_clear` is ignored while any flag is high. Otherwise it drops `fault` on the next edge.
- R10: While `fault` is low, `gate_out` is `gate_in` delayed by one clock. On the clock after `fault` is high, `gate_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lim_we | input | 1 | Limit write strobe |
| lim_ch | input | CH_W | Channel whose limits are written |
| lim_upper | input | 16 | Upper trip limit, raw counts |
| lim_lower | input | 16 | Lower trip limit, raw counts |
| frame_valid | input | 1 | Frame strobe |
| frame_data | input | N_CH*16 | Packed raw samples, channel 0 in the low bits |
| debounce_len | input | 8 | Extra consecutive violating frames needed before a flag |
| gate_in | input | N_GATE | Gate commands from the modulator |
| fault_clear | input | 1 | Request to clear the latched fault |
| range_flag | output | N_CH | Per-channel out-of-range flags |
| fault | output | 1 | Latched fault |
| gate_out | output | N_GATE | Gated PWM commands |

## Verification
The clear request and a newly raised flag can meet in the same cycle. The bench builds a state with the fault latched and no flag high. It then sends a violating frame and places a single-cycle clear pulse on two different edges. If the pulse lands on the edge where the flag is already high, the fault must survive. If it lands one edge earlier, the fault must drop and then rise again on the following edge. Both outcomes are judged at exact cycles, and `gate_out` is checked alongside.

// File: rtl/trip_guard_pkg.sv
`timescale 1ns/1ps
package trip_guard_pkg;

    parameter int SAMPLE_W = 16;
    parameter int DEB_W    = 8;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    // both bounds of one channel, read together in one clock
    typedef struct packed {
        sample_t upper;
        sample_t lower;
    } limit_word_t;

    typedef struct packed {
        logic over;
        logic under;
    } range_t;

    localparam limit_word_t LIMIT_OPEN = '{
        upper: {1'b0, {(SAMPLE_W-1){1'b1}}},
        lower: {1'b1, {(SAMPLE_W-1){1'b0}}}
    };

    function automatic range_t classify(sample_t s, limit_word_t w);
        range_t r;
        r.over  = (s > w.upper);
        r.under = (s < w.lower);
        return r;
    endfunction

endpackage

// File: rtl/trip_guard_limit_ram.sv
`timescale 1ns/1ps
module trip_guard_limit_ram
    import trip_guard_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int CH_W = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [CH_W-1:0]              wr_ch,
    input  limit_word_t                  wr_word,
    output limit_word_t [N_CH-1:0]       rd_q
);

    limit_word_t [N_CH-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CH; i++) begin
                mem[i]  <= LIMIT_OPEN;
                rd_q[i] <= LIMIT_OPEN;
            end
        end else begin
            if (wr_en && (int'(wr_ch) < N_CH))
                mem[wr_ch] <= wr_word;
            rd_q <= mem;
        end
    end

endmodule

// File: rtl/trip_guard_compare.sv
`timescale 1ns/1ps
module trip_guard_compare
    import trip_guard_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [N_CH*SAMPLE_W-1:0]     in_data,
    input  limit_word_t [N_CH-1:0]       lim_q,
    output logic                         cmp_valid,
    output range_t [N_CH-1:0]            cmp_rng
);

    sample_t [N_CH-1:0] s1_q;
    logic               s1_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1_q      <= '0;
            cmp_valid <= 1'b0;
            cmp_rng   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid)
                s1_q <= in_data;
            cmp_valid <= s1_valid;
            for (int i = 0; i < N_CH; i++)
                cmp_rng[i] <= classify(s1_q[i], lim_q[i]);
        end
    end

    // R7: an accepted frame yields a compare result two edges later
    p_cmp_timing_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 cmp_valid);

endmodule

// File: rtl/trip_guard_debounce.sv
`timescale 1ns/1ps
module trip_guard_debounce
    import trip_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  range_t            rng,
    input  logic [DEB_W-1:0]  deb_len,
    output logic              flag
);

    logic [DEB_W-1:0] run_cnt;
    logic             viol;

    assign viol = rng.over | rng.under;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else if (valid) begin
            if (viol) begin
                if (run_cnt >= deb_len)
                    flag <= 1'b1;
                else
                    run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
                flag    <= 1'b0;
            end
        end
    end

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(flag));

    p_first_trip_r5: assert property (@(posedge clk) disable iff (rst)
        (valid && viol && deb_len == '0) |=> flag);

endmodule

// File: rtl/trip_guard_fault_gate.sv
`timescale 1ns/1ps
module trip_guard_fault_gate #(
    parameter int N_CH   = 4,
    parameter int N_GATE = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   flags,
    input  logic              clr,
    input  logic [N_GATE-1:0] gate_in,
    output logic              fault,
    output logic [N_GATE-1:0] gate_out
);

    logic any_flag;
    assign any_flag = |flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault    <= 1'b0;
            gate_out <= '0;
        end else begin
            if (any_flag)
                fault <= 1'b1;
            else if (clr)
                fault <= 1'b0;
            gate_out <= fault ? '0 : gate_in;
        end
    end

    p_fault_sets_r8: assert property (@(posedge clk) disable iff (rst)
        any_flag |=> fault);

    p_clear_works_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !any_flag) |=> !fault);

    p_gate_off_r10: assert property (@(posedge clk) disable iff (rst)
        fault |=> (gate_out == '0));

endmodule

// File: rtl/trip_guard.sv
`timescale 1ns/1ps
module trip_guard
    import trip_guard_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int N_GATE = 6,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       lim_we,
    input  logic [CH_W-1:0]            lim_ch,
    input  logic [SAMPLE_W-1:0]        lim_upper,
    input  logic [SAMPLE_W-1:0]        lim_lower,
    input  logic                       frame_valid,
    input  logic [N_CH*SAMPLE_W-1:0]   frame_data,
    input  logic [DEB_W-1:0]           debounce_len,
    input  logic [N_GATE-1:0]          gate_in,
    input  logic                       fault_clear,
    output logic [N_CH-1:0]            range_flag,
    output logic                       fault,
    output logic [N_GATE-1:0]          gate_out
);

    limit_word_t              wr_word;
    limit_word_t [N_CH-1:0]   lim_q;
    logic                     cmp_valid;
    range_t [N_CH-1:0]        cmp_rng;

    assign wr_word.upper = sample_t'(lim_upper);
    assign wr_word.lower = sample_t'(lim_lower);

    trip_guard_limit_ram #(.N_CH(N_CH), .CH_W(CH_W)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lim_we),
        .wr_ch   (lim_ch),
        .wr_word (wr_word),
        .rd_q    (lim_q)
    );

    trip_guard_compare #(.N_CH(N_CH)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (frame_valid),
        .in_data   (frame_data),
        .lim_q     (lim_q),
        .cmp_valid (cmp_valid),
        .cmp_rng   (cmp_rng)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        trip_guard_debounce u_deb (
            .clk     (clk),
            .rst     (rst),
            .valid   (cmp_valid),
            .rng     (cmp_rng[g]),
            .deb_len (debounce_len),
            .flag    (range_flag[g])
        );
    end

    trip_guard_fault_gate #(.N_CH(N_CH), .N_GATE(N_GATE)) u_fg (
        .clk      (clk),
        .rst      (rst),
        .flags    (range_flag),
        .clr      (fault_clear),
        .gate_in  (gate_in),
        .fault    (fault),
        .gate_out (gate_out)
    );

endmodule

// File: tb/trip_guard_bench.sv
`timescale 1ns/1ps
module trip_guard_bench;

    localparam int N_CH   = 4;
    localparam int N_GATE = 6;
    localparam int CH_W   = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                  rst;
    logic                  lim_we;
    logic [CH_W-1:0]       lim_ch;
    logic [15:0]           lim_upper, lim_lower;
    logic                  frame_valid;
    logic [N_CH*16-1:0]    frame_data;
    logic [7:0]            debounce_len;
    logic [N_GATE-1:0]     gate_in;
    logic                  fault_clear;
    logic [N_CH-1:0]       range_flag;
    logic                  fault;
    logic [N_GATE-1:0]     gate_out;

    trip_guard #(.N_CH(N_CH), .N_GATE(N_GATE)) u_trip_guard (
        .clk(clk), .rst(rst), .lim_we(lim_we), .lim_ch(lim_ch),
        .lim_upper(lim_upper), .lim_lower(lim_lower),
        .frame_valid(frame_valid), .frame_data(frame_data),
        .debounce_len(debounce_len), .gate_in(gate_in),
        .fault_clear(fault_clear), .range_flag(range_flag),
        .fault(fault), .gate_out(gate_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    int m_hi [N_CH];
    int m_lo [N_CH];
    int m_cnt [N_CH];
    bit m_flag [N_CH];
    bit m_fault;
    int fv [N_CH];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int eg;
        for (int c = 0; c < N_CH; c++)
            check(range_flag[c] == m_flag[c], req, $sformatf("flag ch%0d", c),
                  int'(range_flag[c]), int'(m_flag[c]));
        check(fault == m_fault, req, "fault", int'(fault), int'(m_fault));
        eg = m_fault ? 0 : int'(gate_in);
        check(int'(gate_out) == eg, req, "gate_out", int'(gate_out), eg);
    endtask

    task automatic write_lim(input int ch, input int hi, input int lo);
        @(negedge clk);
        lim_we = 1; lim_ch = CH_W'(ch);
        lim_upper = 16'(hi); lim_lower = 16'(lo);
        @(negedge clk);
        lim_we = 0;
        m_hi[ch] = hi; m_lo[ch] = lo;
    endtask

    function automatic void model_frame();
        bit any;
        any = 0;
        for (int c = 0; c < N_CH; c++) begin
            if (fv[c] > m_hi[c] || fv[c] < m_lo[c]) begin
                if (m_cnt[c] >= int'(debounce_len)) m_flag[c] = 1;
                else m_cnt[c]++;
            end else begin
                m_cnt[c] = 0; m_flag[c] = 0;
            end
            any |= m_flag[c];
        end
        if (any) m_fault = 1;
    endfunction

    function automatic bit model_any();
        bit a = 0;
        for (int c = 0; c < N_CH; c++) a |= m_flag[c];
        return a;
    endfunction

    task automatic drive_frame();
        @(negedge clk);
        frame_valid = 1;
        for (int c = 0; c < N_CH; c++) frame_data[16*c +: 16] = 16'(fv[c]);
        @(negedge clk);
        frame_valid = 0;
    endtask

    task automatic send_frame();
        drive_frame();
        model_frame();
        repeat (5) @(negedge clk);
    endtask

    task automatic set_one(input int ch, input int v);
        for (int c = 0; c < N_CH; c++) fv[c] = 0;
        fv[ch] = v;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        fault_clear = 1;
        @(negedge clk);
        fault_clear = 0;
        if (!model_any()) m_fault = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int vals [7];
        rst = 1; lim_we = 0; lim_ch = '0; lim_upper = '0; lim_lower = '0;
        frame_valid = 0; frame_data = '0; debounce_len = 0;
        gate_in = 6'b101101; fault_clear = 0;
        for (int c = 0; c < N_CH; c++) begin
            m_hi[c] = 32767; m_lo[c] = -32768; m_cnt[c] = 0; m_flag[c] = 0;
        end
        m_fault = 0;
        repeat (3) @(negedge clk);
        // R1: reset state (gate_out is held at zero during reset)
        check(range_flag == 0, "R1", "flags in reset", int'(range_flag), 0);
        check(fault == 0, "R1", "fault in reset", int'(fault), 0);
        check(gate_out == 0, "R1", "gate in reset", int'(gate_out), 0);
        rst = 0;
        repeat (2) @(negedge clk);
        check_all("R10");
        // R1: open limits pass extremes
        for (int c = 0; c < N_CH; c++) fv[c] = (c % 2) ? -32768 : 32767;
        send_frame();
        check_all("R1");

        // R2: program limits
        for (int c = 0; c < N_CH; c++) write_lim(c, 100 + 10*c, -100 - 10*c);

        // R3/R4 sweep with debounce 0
        debounce_len = 0;
        for (int c = 0; c < N_CH; c++) begin
            vals[0] = m_lo[c] - 1; vals[1] = m_lo[c]; vals[2] = 0;
            vals[3] = m_hi[c]; vals[4] = m_hi[c] + 1; vals[5] = 32767;
            vals[6] = -32768;
            for (int k = 0; k < 7; k++) begin
                set_one(c, vals[k]);
                send_frame();
                check_all(vals[k] < 0 ? "R4" : "R3");
                set_one(c, 0);
                send_frame();
                check_all("R6");
                pulse_clear();
                check_all("R9");
            end
        end

        // R2: rewrite one channel, new limit applies
        write_lim(1, 20, -20);
        set_one(1, 25);
        send_frame();
        check_all("R2");
        set_one(1, 0); send_frame(); pulse_clear();
        check_all("R9");

        // R5: debounce 3 needs 4 consecutive violations, with idle gaps between
        debounce_len = 3;
        for (int n = 0; n < 4; n++) begin
            set_one(2, -500);
            send_frame();
            check_all("R5");
        end
        // R9: clear ignored while flag high
        pulse_clear();
        check_all("R9");
        // R6: in-range frame resets the run
        set_one(2, 0); send_frame(); check_all("R6");
        pulse_clear(); check_all("R9");
        for (int n = 0; n < 3; n++) begin
            set_one(2, 999); send_frame(); check_all("R6");
        end
        set_one(2, 0); send_frame();
        for (int n = 0; n < 3; n++) begin
            set_one(2, 999); send_frame(); check_all("R5");
        end
        set_one(2, 0); send_frame(); check_all("R6");

        // R7/R8/R10: exact latency, debounce 0, clean state
        debounce_len = 0;
        check(fault == 0, "R7", "fault before latency test", int'(fault), 0);
        set_one(0, 500);
        @(negedge clk);
        frame_valid = 1; frame_data = '0; frame_data[15:0] = 16'(500);
        @(negedge clk); frame_valid = 0;
        check(range_flag[0] == 0, "R7", "flag after edge1", int'(range_flag[0]), 0);
        @(negedge clk);
        check(range_flag[0] == 0, "R7", "flag after edge2", int'(range_flag[0]), 0);
        @(negedge clk);
        check(range_flag[0] == 1, "R7", "flag after edge3", int'(range_flag[0]), 1);
        check(fault == 0, "R8", "fault after edge3", int'(fault), 0);
        @(negedge clk);
        check(fault == 1, "R8", "fault after edge4", int'(fault), 1);
        check(gate_out == gate_in, "R10", "gate after edge4", int'(gate_out), int'(gate_in));
        @(negedge clk);
        check(gate_out == 0, "R10", "gate after edge5", int'(gate_out), 0);
        model_frame();
        repeat (3) @(negedge clk);
        check_all("R8");
        set_one(0, 0); send_frame();
        check_all("R8");   // latched after flag drops

        // Clear meets a rising flag on the same edge: ignored
        set_one(3, 4000);
        drive_frame();
        @(negedge clk);
        @(negedge clk);
        fault_clear = 1;
        @(negedge clk);
        fault_clear = 0;
        check(fault == 1, "R9", "clear with flag rising", int'(fault), 1);
        model_frame();
        repeat (3) @(negedge clk);
        check_all("R9");
        set_one(3, 0); send_frame();

        // Clear one edge before the flag: fault drops, then rises again
        set_one(3, -4000);
        drive_frame();
        @(negedge clk);
        fault_clear = 1;
        @(negedge clk);
        fault_clear = 0;
        check(fault == 0, "R9", "clear before flag", int'(fault), 0);
        @(negedge clk);
        check(fault == 1, "R8", "refault after flag", int'(fault), 1);
        model_frame();
        repeat (3) @(negedge clk);
        check_all("R8");

        // R10: with fault cleared, gates pass with one-clock delay
        set_one(3, 0); send_frame(); pulse_clear();
        gate_in = 6'b010011;
        @(negedge clk);
        check(gate_out == 6'b010011, "R10", "gate pass", int'(gate_out), 19);
        check_all("R10");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule